// File: doc/BRIEF.md
# Shared-Adder Arithmetic/Logic Unit

This block is an N-bit arithmetic/logic unit (8 bits by default). A 3-bit opcode selects one of eight functions: add, subtract, increment, pass, AND, OR, XOR and NOT. All eight functions go through one ripple-carry adder. Each bit has a small extender stage that rewrites the A and B operands before they reach the adder. A carry-in generator supplies the adder's carry-in. With these two pieces, subtraction and increment need no dedicated hardware, and no wide result multiplexer is needed.

The adder output feeds a result register with a load enable. A result appears on the output one clock after an edge at which the load enable was high. Arithmetic wraps modulo 2^N, and any carry out of the top bit is dropped.

Top module: `alu_shared_adder`

## Requirements
- R1: While the active-low asynchronous reset is asserted, the result output is all zeros.
- R2: Opcode 3'b000 loads (A + B) mod 2^N; the carry beyond bit N-1 is discarded.
- R3: Opcode 3'b001 loads (A - B) mod 2^N, formed as A plus the inverted B plus a carry-in of 1.
- R4: Opcode 3'b010 loads (A + 1) mod 2^N, so an all-ones A yields zero.
- R5: Opcode 3'b011 loads A unchanged.
- R6: Opcode 3'b100 loads the bitwise AND of A and B.
- R7: Opcode 3'b101 loads the bitwise OR of A and B.
- R8: Opcode 3'b110 loads the bitwise XOR of A and B.
- R9: Opcode 3'b111 loads the bitwise complement of A; B has no effect.
- R10: When the load enable is low at a clock edge, the result output keeps its value whatever A, B and the opcode are.
- R11: The output changes only at a rising clock edge at which the load enable is high, and it shows the function of the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| op_i | input | 3 | Function select |
| ld_i | input | 1 | Result register load enable |
| s_o | output | W | Registered result |

## Verification
The assertions check every opcode on every loaded cycle. Each one compares the registered output with the function of the previous cycle's operands. Further assertions check that the output holds on cycles without a load and stays zero during reset. The bench covers what a per-cycle property cannot show on its own. It applies a fixed operand pair across all eight opcodes, tests wrap points such as all-ones plus one and zero minus one, and checks that the output is unchanged just before the load edge and has changed just after it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_PASS = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOT  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_ext_bit.sv
module alu_ext_bit
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  alu_op_e op_i,
  output logic    ia_o,
  output logic    ib_o
);
  always_comb begin
    ia_o = a_i;
    ib_o = 1'b0;
    case (op_i)
      OP_ADD:  ib_o = b_i;
      OP_SUB:  ib_o = ~b_i;
      OP_INC:  ib_o = 1'b0;
      OP_PASS: ib_o = 1'b0;
      // logic ops: result on first input, second input zero
      OP_AND:  ia_o = a_i & b_i;
      OP_OR:   ia_o = a_i | b_i;
      OP_XOR:  ia_o = a_i ^ b_i;
      OP_NOT:  ia_o = ~a_i;
      default: begin
        ia_o = a_i;
        ib_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_cin_gen.sv
module alu_cin_gen
  import alu_pkg::*;
(
  input  alu_op_e op_i,
  output logic    cin_o
);
  always_comb begin
    case (op_i)
      OP_SUB, OP_INC: cin_o = 1'b1;
      default:        cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] ia_i,
  input  logic [W-1:0] ib_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i] = ia_i[i] ^ ib_i[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = (ia_i[i] & ib_i[i]) | (c[i] & (ia_i[i] ^ ib_i[i]));
    end
  end
endmodule

// File: rtl/alu_result_reg.sv
module alu_result_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_shared_adder.sv
module alu_shared_adder
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  input  logic         ld_i,
  output logic [W-1:0] s_o
);
  alu_op_e      op;
  logic [W-1:0] ia, ib, sum;
  logic         cin;

  assign op = alu_op_e'(op_i);

  for (genvar i = 0; i < W; i++) begin : g_ext
    alu_ext_bit u_ext (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .op_i (op),
      .ia_o (ia[i]),
      .ib_o (ib[i])
    );
  end

  alu_cin_gen u_cin (
    .op_i  (op),
    .cin_o (cin)
  );

  alu_ripple_add #(.W(W)) u_add (
    .ia_i  (ia),
    .ib_i  (ib),
    .cin_i (cin),
    .s_o   (sum)
  );

  alu_result_reg #(.W(W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_i),
    .d_i    (sum),
    .q_o    (s_o)
  );
endmodule

// File: rtl/alu_shared_adder_chk.sv
module alu_shared_adder_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic         ld_i,
  input logic [W-1:0] s_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_ZERO: assert (s_o == '0) else $error("reset value"); // R1
    end
  end

  AST_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b000) |=> s_o == ($past(a_i) + $past(b_i))); // R2
  AST_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b001) |=> s_o == ($past(a_i) - $past(b_i))); // R3
  AST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b010) |=> s_o == ($past(a_i) + ONE)); // R4
  AST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b011) |=> s_o == $past(a_i)); // R5
  AST_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b100) |=> s_o == ($past(a_i) & $past(b_i))); // R6
  AST_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b101) |=> s_o == ($past(a_i) | $past(b_i))); // R7
  AST_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b110) |=> s_o == ($past(a_i) ^ $past(b_i))); // R8
  AST_NOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && op_i == 3'b111) |=> s_o == ~$past(a_i)); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(s_o)); // R10
endmodule

bind alu_shared_adder alu_shared_adder_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .op_i   (op_i),
  .ld_i   (ld_i),
  .s_o    (s_o)
);

// File: tb/alu_shared_adder_bench.sv
module alu_shared_adder_bench;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [2:0]   op_i = '0;
  logic         ld_i = 1'b0;
  logic [W-1:0] s_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  alu_shared_adder #(.W(W)) u_alu_shared_adder (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .op_i(op_i), .ld_i(ld_i), .s_o(s_o)
  );

  function automatic logic [W-1:0] ref_fn(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a + 8'd1;
      3'd3: return a;
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return a ^ b;
      default: return ~a;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
      3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the next posedge
  task automatic apply(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, logic ld);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; ld_i = ld;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    a_i = 8'hAA; b_i = 8'h55; ld_i = 1'b1; op_i = 3'd5;
    rst_ni = 1'b0;
    @(posedge clk_i); #1;
    check("R1", s_o, '0);
    @(negedge clk_i);
    ld_i = 1'b0; rst_ni = 1'b1;
  endtask

  task automatic t_reference;
    logic [W-1:0] exp_tab [8] = '{8'b00010100, 8'b00001010, 8'b00010000, 8'b00001111,
                                  8'b00000101, 8'b00001111, 8'b00001010, 8'b11110000};
    for (int k = 0; k < 8; k++) begin
      apply(3'(k), 8'b00001111, 8'b00000101, 1'b1);
      check(req_of(3'(k)), s_o, exp_tab[k]);
    end
  endtask

  task automatic t_wrap;
    apply(3'd0, 8'hFF, 8'h01, 1'b1); check("R2", s_o, 8'h00);
    apply(3'd0, 8'h80, 8'h80, 1'b1); check("R2", s_o, 8'h00);
    apply(3'd1, 8'h00, 8'h01, 1'b1); check("R3", s_o, 8'hFF);
    apply(3'd1, 8'h05, 8'h05, 1'b1); check("R3", s_o, 8'h00);
    apply(3'd2, 8'hFF, 8'h3C, 1'b1); check("R4", s_o, 8'h00);
    apply(3'd7, 8'h00, 8'hFF, 1'b1); check("R9", s_o, 8'hFF);
  endtask

  task automatic t_sweep;
    logic [W-1:0] a = 8'h5A, b = 8'hC3;
    for (int i = 0; i < 64; i++) begin
      a = a * 8'd29 + 8'd7;
      b = b * 8'd13 + 8'd91;
      apply(3'(i), a, b, 1'b1);
      check(req_of(3'(i)), s_o, ref_fn(3'(i), a, b));
    end
  endtask

  task automatic t_hold;
    logic [W-1:0] held;
    apply(3'd0, 8'h21, 8'h12, 1'b1);
    held = 8'h33;
    check("R2", s_o, held);
    for (int i = 0; i < 8; i++) begin
      apply(3'(i), 8'hF0 ^ 8'(i), 8'h0F, 1'b0);
      check("R10", s_o, held);
    end
  endtask

  task automatic t_latency;
    apply(3'd3, 8'h44, 8'h00, 1'b1);
    check("R11", s_o, 8'h44);
    @(negedge clk_i);
    op_i = 3'd6; a_i = 8'hF0; b_i = 8'h3C; ld_i = 1'b1;
    #4;
    check("R11", s_o, 8'h44);
    @(posedge clk_i); #1;
    check("R11", s_o, 8'hCC);
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_reference();
    t_wrap();
    t_sweep();
    t_hold();
    t_latency();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule